// File: doc/BRIEF.md
# MFM Track Stream Emulator

This block stands in for the read side of a legacy MFM hard-disk drive, so that an unmodified disk controller can read from it. A whole cylinder sits in an external RAM with synchronous reads. The block picks one track from that RAM by head number and plays every byte of the track as a serial MFM cell stream, without pause, revolution after revolution. An index pulse marks the start of each track. The controller reads only the sectors it wants and the emulator has no way of knowing which ones those are, so gap fill, sector framing and data all go out on every revolution.

The rotational position is a byte offset shared by all heads. A head change therefore picks up mid-revolution at the same angle, with no gap and no fetch from bulk storage. Each MFM cell is paced by a cell-rate enable. At the nominal 5 Mb/s data rate this is 10 M cells per second.

Top module: `mfm_track_streamer`

## Requirements
- R1: `driveReady` is 0 after reset. It follows `cylLoaded` with a latency of one clock.
- R2: While `driveReady` is 0, `indexOut` is 0. From the second clock with `driveReady` at 0, `mfmOut` is also 0.
- R3: Each data bit goes out as two cells: a clock cell, then a data cell. The data cell equals the bit. The clock cell is 1 only when both the bit and the bit sent before it are 0. At the start of a stream, the bit before the first one counts as 0.
- R4: Each byte goes out most significant bit first. Bytes go in ascending offset order, and offset TRACK_BYTES-1 is followed directly by offset 0, with no break.
- R5: Sampled before a cell's enable edge, `indexOut` is 1 exactly when the byte holding that cell has an offset below INDEX_BYTES.
- R6: `bufAddr` equals head × TRACK_BYTES + offset. `bufData` is taken one clock after the address is presented.
- R7: A change on `headSel` made at least two clocks before a byte boundary takes effect for the next byte. The offset keeps counting without a break.
- R8: A `headSel` value of HEADS or more is served as head HEADS-1.
- R9: One `cellEn` pulse emits exactly one cell. With no enable, `mfmOut` holds its value.
- R10: When `cylLoaded` drops and is raised again, the stream restarts at offset 0 with index asserted and the bit history cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellEn | input | 1 | One pulse per MFM cell |
| cylLoaded | input | 1 | Cylinder buffer holds valid data |
| headSel | input | HEAD_W | Selected head |
| bufData | input | 8 | Cylinder RAM read data, one clock after the address |
| bufAddr | output | ADDR_W | Cylinder RAM byte address |
| mfmOut | output | 1 | Serial MFM read data |
| indexOut | output | 1 | Track start marker |
| driveReady | output | 1 | Drive ready |

## Verification
The bench drives a small track so that it can follow several full revolutions. This exposes a wrap that skips offset 0 or emits a stale byte, as well as an index pulse that sits on the wrong bytes. Zero-valued bytes and bit runs test the clock-cell rule: a design that takes its history from the wrong bit would put a clock pulse between a 1 and a 0. The bench switches heads mid-byte and also selects a head past the last one. A design that reset the offset, or addressed a head outside the buffer, would then stream the wrong bytes. Finally, the bench drops and restores the loaded flag, and holds off the cell enable, to catch state left over from the previous stream or output that moves with no enable.

// File: rtl/mfm_stream_pkg.sv
package mfm_stream_pkg;
  typedef struct packed {
    logic preload;   // idle: keep byte 0 staged, clear history
    logic emit;      // drive the current cell this clock
    logic dataCell;  // current cell is the data half of a bit
    logic advance;   // bit finished, step to next bit
    logic loadByte;  // byte finished, take next byte from buffer
  } mfm_strobe_t;
endpackage

// File: rtl/mfm_stream_ctrl.sv
module mfm_stream_ctrl
  import mfm_stream_pkg::*;
#(
  parameter int TRACK_BYTES = 10416,
  parameter int HEADS       = 15,
  parameter int INDEX_BYTES = 4,
  parameter int OFF_W       = 14,
  parameter int HEAD_W      = 4,
  parameter int ADDR_W      = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellEn,
  input  logic              cylLoaded,
  input  logic [HEAD_W-1:0] headSel,
  output logic              ready,
  output logic              indexOut,
  output logic [ADDR_W-1:0] bufAddr,
  output mfm_strobe_t       strobe
);
  logic             phase;
  logic [2:0]       bitIdx;
  logic [OFF_W-1:0] byteOff;
  logic [OFF_W-1:0] nextOff;
  logic [HEAD_W-1:0] headEff;

  always_comb begin
    if (!ready)                                nextOff = '0;
    else if (byteOff == OFF_W'(TRACK_BYTES-1)) nextOff = '0;
    else                                       nextOff = byteOff + 1'b1;
  end

  always_comb begin
    if (int'(headSel) >= HEADS) headEff = HEAD_W'(HEADS-1);
    else                        headEff = headSel;
  end

  assign bufAddr = ADDR_W'(headEff) * ADDR_W'(TRACK_BYTES) + ADDR_W'(nextOff);
  assign indexOut = ready && (byteOff < OFF_W'(INDEX_BYTES));

  always_comb begin
    strobe.preload  = !ready;
    strobe.emit     = ready && cellEn;
    strobe.dataCell = phase;
    strobe.advance  = ready && cellEn && phase;
    strobe.loadByte = ready && cellEn && phase && (bitIdx == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready   <= 1'b0;
      phase   <= 1'b0;
      bitIdx  <= '0;
      byteOff <= '0;
    end else begin
      ready <= cylLoaded;
      if (!ready) begin
        phase   <= 1'b0;
        bitIdx  <= '0;
        byteOff <= '0;
      end else if (cellEn) begin
        phase <= ~phase;
        if (phase) begin
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == 3'd7) byteOff <= nextOff;
        end
      end
    end
  end
endmodule

// File: rtl/mfm_stream_dp.sv
module mfm_stream_dp
  import mfm_stream_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mfm_strobe_t strobe,
  input  logic [7:0]  bufData,
  output logic        mfmOut
);
  logic [7:0] shifter;
  logic       prevBit;
  logic       curBit;
  logic       cellVal;

  assign curBit  = shifter[7];
  assign cellVal = strobe.dataCell ? curBit : ~(prevBit | curBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter <= '0;
      prevBit <= 1'b0;
      mfmOut  <= 1'b0;
    end else if (strobe.preload) begin
      shifter <= bufData;
      prevBit <= 1'b0;
      mfmOut  <= 1'b0;
    end else begin
      if (strobe.emit) mfmOut <= cellVal;
      if (strobe.advance) begin
        prevBit <= curBit;
        shifter <= strobe.loadByte ? bufData : {shifter[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mfm_track_streamer.sv
module mfm_track_streamer
  import mfm_stream_pkg::*;
#(
  parameter int TRACK_BYTES = 10416,
  parameter int HEADS       = 15,
  parameter int INDEX_BYTES = 4,
  localparam int OFF_W  = $clog2(TRACK_BYTES),
  localparam int HEAD_W = (HEADS > 1) ? $clog2(HEADS) : 1,
  localparam int ADDR_W = $clog2(HEADS * TRACK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellEn,
  input  logic              cylLoaded,
  input  logic [HEAD_W-1:0] headSel,
  input  logic [7:0]        bufData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              mfmOut,
  output logic              indexOut,
  output logic              driveReady
);
  mfm_strobe_t strobe;

  mfm_stream_ctrl #(
    .TRACK_BYTES(TRACK_BYTES), .HEADS(HEADS), .INDEX_BYTES(INDEX_BYTES),
    .OFF_W(OFF_W), .HEAD_W(HEAD_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cellEn(cellEn), .cylLoaded(cylLoaded),
    .headSel(headSel), .ready(driveReady), .indexOut(indexOut),
    .bufAddr(bufAddr), .strobe(strobe)
  );

  mfm_stream_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufData(bufData), .mfmOut(mfmOut)
  );
endmodule

// File: rtl/mfm_track_chk.sv
module mfm_track_chk #(
  parameter int TRACK_BYTES = 10416,
  parameter int HEADS       = 15,
  parameter int ADDR_W      = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              cellEn,
  input logic              cylLoaded,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              mfmOut,
  input logic              indexOut,
  input logic              driveReady
);
  // R1
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveReady |-> $past(cylLoaded));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!driveReady && $past(!driveReady)) |-> !mfmOut);

  // R3
  no_adjacent_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveReady && cellEn && mfmOut) |=> !mfmOut);

  // R5
  index_on_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(indexOut) && $past(driveReady)) |-> $past(cellEn));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(bufAddr) < HEADS * TRACK_BYTES);

  // R9
  hold_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveReady && !cellEn) |=> $stable(mfmOut));
endmodule

bind mfm_track_streamer mfm_track_chk #(
  .TRACK_BYTES(TRACK_BYTES), .HEADS(HEADS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cellEn(cellEn), .cylLoaded(cylLoaded),
  .bufAddr(bufAddr), .mfmOut(mfmOut), .indexOut(indexOut),
  .driveReady(driveReady)
);

// File: tb/test_mfm_track_streamer.sv
module test_mfm_track_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 8;
  localparam int H   = 3;
  localparam int IDX = 2;
  localparam int HW  = 2;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellEn = 1'b0;
  logic cylLoaded = 1'b0;
  logic [HW-1:0] headSel = '0;
  logic [7:0] bufData = '0;
  logic [AW-1:0] bufAddr;
  logic mfmOut, indexOut, driveReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int mOff, mBit, mPhase, mPrev;
  logic [7:0] mByte;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfm_track_streamer #(.TRACK_BYTES(T), .HEADS(H), .INDEX_BYTES(IDX)) i_mfm_track_streamer (
    .clk(clk), .rstN(rstN), .cellEn(cellEn), .cylLoaded(cylLoaded),
    .headSel(headSel), .bufData(bufData), .bufAddr(bufAddr),
    .mfmOut(mfmOut), .indexOut(indexOut), .driveReady(driveReady)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 91) ^ (a >> 1));
  endfunction

  function automatic int effHead();
    return (int'(headSel) >= H) ? H - 1 : int'(headSel);
  endfunction

  // synchronous-read cylinder RAM model
  always @(posedge clk) bufData <= pat(int'(bufAddr));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStart();
    mOff = 0; mBit = 0; mPhase = 0; mPrev = 0;
    mByte = pat(effHead() * T);
  endtask

  task automatic sendCell();
    int b, e;
    b = int'(mByte[7 - mBit]);
    e = (mPhase == 1) ? b : ((mPrev == 0 && b == 0) ? 1 : 0);
    chk(indexOut == (mOff < IDX), "R5 index", int'(indexOut), int'(mOff < IDX));
    cellEn = 1'b1;
    @(posedge clk); @(negedge clk);
    cellEn = 1'b0;
    chk(mfmOut == e[0], "R3/R4 cell", int'(mfmOut), e);
    if (mPhase == 1) begin
      mPrev = b;
      if (mBit == 7) begin
        mBit = 0;
        mOff = (mOff + 1) % T;
        mByte = pat(effHead() * T + mOff);
      end else mBit++;
    end
    mPhase ^= 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0; cylLoaded = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(driveReady == 1'b0, "R1 ready after reset", int'(driveReady), 0);
    for (int i = 0; i < 6; i++) begin
      cellEn = 1'b1; @(posedge clk); @(negedge clk); cellEn = 1'b0;
      chk(mfmOut == 1'b0, "R2 idle data", int'(mfmOut), 0);
      chk(indexOut == 1'b0, "R2 idle index", int'(indexOut), 0);
    end
  endtask

  task automatic tBringUp(int head);
    headSel = HW'(head);
    @(negedge clk);
    cylLoaded = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(driveReady == 1'b1, "R1 ready follows load", int'(driveReady), 1);
    chk(bufAddr == AW'(effHead() * T + 1), "R6 address", int'(bufAddr), effHead() * T + 1);
    modelStart();
  endtask

  task automatic tRevolutions(int revs);
    for (int i = 0; i < revs * T * 16; i++) sendCell();
  endtask

  task automatic tHeadSwitch(int head, int cells);
    while (mBit != 3) sendCell();
    headSel = HW'(head);
    @(negedge clk);
    chk(bufAddr == AW'(effHead() * T + (mOff + 1) % T), "R7/R8 address",
        int'(bufAddr), effHead() * T + (mOff + 1) % T);
    for (int i = 0; i < cells; i++) sendCell();
  endtask

  task automatic tHold();
    logic held;
    while (mBit != 5) sendCell();
    held = mfmOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(mfmOut == held, "R9 hold without enable", int'(mfmOut), int'(held));
    end
    for (int i = 0; i < 20; i++) sendCell();
  endtask

  task automatic tRestart();
    while (mOff != 5) sendCell();
    cylLoaded = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(driveReady == 1'b0, "R1 ready drops", int'(driveReady), 0);
    chk(indexOut == 1'b0, "R2 index low", int'(indexOut), 0);
    @(negedge clk);
    chk(mfmOut == 1'b0, "R2 data low", int'(mfmOut), 0);
    tBringUp(1);
    chk(indexOut == 1'b1, "R10 index at restart", int'(indexOut), 1);
    tRevolutions(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tBringUp(0);
    tRevolutions(2);
    tHeadSwitch(2, 200);
    tHeadSwitch(3, 200);
    tHeadSwitch(1, 40);
    tHold();
    tRestart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule